// File: doc/BRIEF.md
# Omega Multistage Switch Network

This block moves up to `N_PORTS` flits per cycle from numbered input ports to numbered output ports through an Omega interconnect. The interconnect is made of log2(`N_PORTS`) stages. In each stage the flits are first reordered by a perfect shuffle, which rotates the position index one bit to the left. They then enter `N_PORTS`/2 two-by-two switches. Each switch either passes both flits straight through or crosses them over. The choice is made from one bit of each flit's destination address, so the network needs no central routing table. Each flit carries a valid bit, a destination port number and a payload.

The network is blocking. Two flits can need the same internal link even when their destinations differ. When that happens, one flit is dropped and its source port raises a blocked flag. Nothing is buffered and nothing is retried. The caller sees which inputs were refused and may present them again in a later cycle. Results are registered, so the outputs and blocked flags for one input cycle appear one clock later.

Top module: `omega_net`

## Requirements
- R1: When an input flit is valid and not refused, its payload appears at the output whose index equals its destination, with that output's valid bit set, one clock after it was presented. Input port i uses bits [i*AW +: AW] of `in_dest` and bits [i*DATA_W +: DATA_W] of `in_data`. Output j uses bits [j*DATA_W +: DATA_W] of `out_data`.
- R2: Every valid input is either delivered or flagged in `in_blocked`, never both. The number of set `out_valid` bits plus the number of set `in_blocked` bits equals the number of valid inputs from the previous cycle.
- R3: An input whose valid bit is low produces no output and is never flagged. Its destination and payload change nothing: the other inputs get the same result as if it were absent.
- R4: A single valid input is delivered to any destination.
- R5: In stage k (k = 0 first), a switch sends a flit to its upper output when destination bit AW-1-k is 0 and to its lower output when that bit is 1. This happens after a shuffle that moves position p to its left-rotated index. When both flits of a switch need the same output, the flit at the even (upper) position wins and the other is flagged. For example, when input 2 goes to 7 and input 6 goes to 4, input 6 is blocked and input 2 is delivered.
- R6: When every valid input targets its own index (the identity pattern), nothing is blocked.
- R7: When all valid inputs share one destination, exactly one of them is delivered.
- R8: While `rst` is high (synchronous, active high), `out_valid`, `out_data` and `in_blocked` are all zero after the next clock edge.
- R9: `out_data` is zero in every output slot whose valid bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_PORTS | Valid bit per input port |
| in_dest | input | N_PORTS*AW | Destination port number per input |
| in_data | input | N_PORTS*DATA_W | Payload per input |
| out_valid | output | N_PORTS | Delivered-flit valid per output port |
| out_data | output | N_PORTS*DATA_W | Delivered payload per output port |
| in_blocked | output | N_PORTS | Set for each valid input that lost a link |

## Verification
A reference model in the bench walks each flit along its path stage by stage. It claims links in ascending order of shuffled position, which gives the upper flit priority at each switch. Directed patterns are run against this model:
- Every single-input route tells apart a wrong shuffle or a wrong destination bit, because each of them misdelivers a lone flit.
- The identity pattern and the all-to-one pattern test the two extremes of contention.
- The named 2→7 and 6→4 pair shows which input wins a tie.
- Masked inputs that carry clashing destinations show that an invalid flit takes no link.

Random masks and destinations then mix partial contention at every stage.

// File: rtl/omega_net.sv
module omega_net #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 16,
  parameter int REG_OUT = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_PORTS-1:0]        in_valid,
  input  logic [N_PORTS*$clog2(N_PORTS)-1:0] in_dest,
  input  logic [N_PORTS*DATA_W-1:0] in_data,
  output logic [N_PORTS-1:0]        out_valid,
  output logic [N_PORTS*DATA_W-1:0] out_data,
  output logic [N_PORTS-1:0]        in_blocked
);
  localparam int AW = $clog2(N_PORTS);
  localparam int ST = AW;
  localparam int H  = N_PORTS / 2;

  logic              vld [ST+1][N_PORTS];
  logic [AW-1:0]     dst [ST+1][N_PORTS];
  logic [AW-1:0]     src [ST+1][N_PORTS];
  logic [DATA_W-1:0] dat [ST+1][N_PORTS];

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    assign vld[0][i] = in_valid[i];
    assign dst[0][i] = in_dest[i*AW +: AW];
    assign src[0][i] = AW'(i);
    assign dat[0][i] = in_data[i*DATA_W +: DATA_W];
  end

  // after the left-rotate shuffle, switch j sees positions j (upper) and j+H (lower)
  for (genvar k = 0; k < ST; k++) begin : g_stage
    for (genvar j = 0; j < H; j++) begin : g_sw
      logic a_v, a_b, b_b, b_go;
      logic up_a, up_b, lo_a, lo_b;
      assign a_v  = vld[k][j];
      assign a_b  = dst[k][j][AW-1-k];
      assign b_b  = dst[k][j+H][AW-1-k];
      assign b_go = vld[k][j+H] & ~(a_v & (a_b == b_b));
      assign up_a = a_v  & ~a_b;
      assign up_b = b_go & ~b_b;
      assign lo_a = a_v  &  a_b;
      assign lo_b = b_go &  b_b;

      assign vld[k+1][2*j]   = up_a | up_b;
      assign dst[k+1][2*j]   = up_a ? dst[k][j] : dst[k][j+H];
      assign src[k+1][2*j]   = up_a ? src[k][j] : src[k][j+H];
      assign dat[k+1][2*j]   = up_a ? dat[k][j] : dat[k][j+H];

      assign vld[k+1][2*j+1] = lo_a | lo_b;
      assign dst[k+1][2*j+1] = lo_a ? dst[k][j] : dst[k][j+H];
      assign src[k+1][2*j+1] = lo_a ? src[k][j] : src[k][j+H];
      assign dat[k+1][2*j+1] = lo_a ? dat[k][j] : dat[k][j+H];
    end
  end

  logic [N_PORTS-1:0]        ov_c, dlv_c, blk_c;
  logic [N_PORTS*DATA_W-1:0] od_c;

  always_comb begin
    ov_c  = '0;
    od_c  = '0;
    dlv_c = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (vld[ST][p]) begin
        ov_c[p]                = 1'b1;
        od_c[p*DATA_W +: DATA_W] = dat[ST][p];
        dlv_c[src[ST][p]]      = 1'b1;
      end
    end
  end

  assign blk_c = in_valid & ~dlv_c;

  if (REG_OUT != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid  <= '0;
        out_data   <= '0;
        in_blocked <= '0;
      end else begin
        out_valid  <= ov_c;
        out_data   <= od_c;
        in_blocked <= blk_c;
      end
    end
  end else begin : g_comb
    assign out_valid  = ov_c;
    assign out_data   = od_c;
    assign in_blocked = blk_c;
  end
endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int N_PORTS = 8,
  parameter int REG_OUT = 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_PORTS-1:0]        in_valid,
  input logic [N_PORTS*$clog2(N_PORTS)-1:0] in_dest,
  input logic [N_PORTS-1:0]        out_valid,
  input logic [N_PORTS-1:0]        in_blocked
);
  localparam int AW = $clog2(N_PORTS);

  logic armed;
  logic ident;

  always_ff @(posedge clk) armed <= !rst;

  always_comb begin
    ident = (in_valid != '0);
    for (int i = 0; i < N_PORTS; i++)
      if (in_valid[i] && (in_dest[i*AW +: AW] != AW'(i))) ident = 1'b0;
  end

  if (REG_OUT != 0) begin : g_props
    AST_BLOCK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst || !armed)
      (in_blocked & ~$past(in_valid)) == '0); // R3
    AST_FLIT_CONSERVED: assert property (@(posedge clk) disable iff (rst || !armed)
      ($countones(out_valid) + $countones(in_blocked)) == $countones($past(in_valid))); // R2
    AST_LONE_PASSES: assert property (@(posedge clk) disable iff (rst || !armed)
      $onehot($past(in_valid)) |-> (in_blocked == '0)); // R4
    AST_IDENT_CLEAR: assert property (@(posedge clk) disable iff (rst || !armed)
      $past(ident) |-> (in_blocked == '0)); // R6
    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (rst || !armed)
      ($past(in_valid) == '0) |-> (out_valid == '0)); // R3
  end
endmodule

bind omega_net omega_net_chk #(.N_PORTS(N_PORTS), .REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest),
  .out_valid(out_valid), .in_blocked(in_blocked)
);

// File: tb/omega_net_tb_top.sv
`timescale 1ns/1ps
module omega_net_tb_top;
  localparam int N  = 8;
  localparam int AW = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    in_valid = '0;
  logic [N*AW-1:0] in_dest  = '0;
  logic [N*DW-1:0] in_data  = '0;
  logic [N-1:0]    out_valid;
  logic [N*DW-1:0] out_data;
  logic [N-1:0]    in_blocked;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  omega_net #(.N_PORTS(N), .DATA_W(DW), .REG_OUT(1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .in_blocked(in_blocked)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // path walk: claim links in ascending shuffled position, upper flit first
  logic [N-1:0]    e_v, e_b;
  logic [N*DW-1:0] e_d;
  task automatic model(input logic [N-1:0] v, input logic [N*AW-1:0] d, input logic [N*DW-1:0] x);
    int occ[N];
    int nxt[N];
    e_v = '0; e_b = '0; e_d = '0;
    for (int i = 0; i < N; i++) occ[i] = v[i] ? i : -1;
    for (int k = 0; k < AW; k++) begin
      for (int i = 0; i < N; i++) nxt[i] = -1;
      for (int q = 0; q < N; q++) begin
        int p;
        int s;
        int t;
        p = (q >> 1) | ((q & 1) << (AW-1));
        s = occ[p];
        if (s >= 0) begin
          t = (q & ~1) | int'(d[s*AW + AW-1-k]);
          if (nxt[t] < 0) nxt[t] = s;
          else e_b[s] = 1'b1;
        end
      end
      for (int i = 0; i < N; i++) occ[i] = nxt[i];
    end
    for (int t = 0; t < N; t++)
      if (occ[t] >= 0) begin
        e_v[t] = 1'b1;
        e_d[t*DW +: DW] = x[occ[t]*DW +: DW];
      end
  endtask

  task automatic run_vec(input logic [N-1:0] v, input logic [N*AW-1:0] d, input logic [N*DW-1:0] x);
    in_valid = v; in_dest = d; in_data = x;
    model(v, d, x);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == e_v,   "R1 out_valid",  128'(out_valid),  128'(e_v));
    chk(out_data == e_d,    "R1/R9 out_data", 128'(out_data),  128'(e_d));
    chk(in_blocked == e_b,  "R2/R5 blocked", 128'(in_blocked), 128'(e_b));
    chk(($countones(out_valid) + $countones(in_blocked)) == $countones(v),
        "R2 conservation", 128'($countones(out_valid) + $countones(in_blocked)), 128'($countones(v)));
  endtask

  function automatic logic [N*DW-1:0] tag_data(input int salt);
    logic [N*DW-1:0] x;
    for (int i = 0; i < N; i++) x[i*DW +: DW] = DW'((i << 12) | ((salt * 37 + i * 5) & 12'hfff));
    return x;
  endfunction

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N*AW-1:0] d;
    logic [N-1:0]    v;
    void'($urandom(32'd1234));

    // R8: inputs active during reset must not reach the outputs
    @(negedge clk);
    in_valid = '1; in_data = tag_data(1);
    for (int i = 0; i < N; i++) in_dest[i*AW +: AW] = AW'(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == '0,  "R8 out_valid",  128'(out_valid),  128'(0));
    chk(out_data == '0,   "R8 out_data",   128'(out_data),   128'(0));
    chk(in_blocked == '0, "R8 in_blocked", 128'(in_blocked), 128'(0));
    rst = 1'b0;
    in_valid = '0;

    // R4: every lone route
    for (int s = 0; s < N; s++)
      for (int t = 0; t < N; t++) begin
        d = '0;
        d[s*AW +: AW] = AW'(t);
        run_vec(N'(1) << s, d, tag_data(s + t));
        chk(in_blocked == '0 && out_valid == (N'(1) << t), "R4 lone delivered",
            128'({out_valid, in_blocked}), 128'({N'(1) << t, N'(0)}));
      end

    // R6: identity
    for (int i = 0; i < N; i++) d[i*AW +: AW] = AW'(i);
    run_vec('1, d, tag_data(3));
    chk(in_blocked == '0 && out_valid == '1, "R6 identity", 128'({out_valid, in_blocked}), 128'({N'('1), N'(0)}));

    // R5: named tie, 2->7 and 6->4, upper (input 2) wins
    d = '0;
    d[2*AW +: AW] = 3'd7;
    d[6*AW +: AW] = 3'd4;
    run_vec(8'b0100_0100, d, tag_data(4));
    chk(in_blocked == 8'b0100_0000, "R5 tie blocked", 128'(in_blocked), 128'(8'b0100_0000));
    chk(out_valid == 8'b1000_0000 && out_data[7*DW +: DW] == tag_data(4)[2*DW +: DW],
        "R5 tie winner", 128'({out_valid, out_data[7*DW +: DW]}), 128'({8'b1000_0000, tag_data(4)[2*DW +: DW]}));

    // R7: all to one destination
    for (int t = 0; t < N; t++) begin
      for (int i = 0; i < N; i++) d[i*AW +: AW] = AW'(t);
      run_vec('1, d, tag_data(10 + t));
      chk(out_valid == (N'(1) << t), "R7 single winner", 128'(out_valid), 128'(N'(1) << t));
    end

    // R3: masked input with clashing destination changes nothing for input 2
    d = '0;
    d[2*AW +: AW] = 3'd7;
    d[6*AW +: AW] = 3'd4;
    run_vec(8'b0000_0100, d, tag_data(5));
    chk(in_blocked == '0 && out_valid == 8'b1000_0000, "R3 masked ignored",
        128'({out_valid, in_blocked}), 128'({8'b1000_0000, N'(0)}));
    for (int i = 0; i < N; i++) d[i*AW +: AW] = 3'd5;
    run_vec('0, d, tag_data(6));
    chk(out_valid == '0 && in_blocked == '0 && out_data == '0, "R3 all masked",
        128'({out_valid, in_blocked}), 128'(0));

    // random mixes
    for (int n = 0; n < 400; n++) begin
      v = N'($urandom);
      for (int i = 0; i < N; i++) d[i*AW +: AW] = AW'($urandom);
      run_vec(v, d, tag_data(n + 100));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule